// File: doc/BRIEF.md
# Two-Wire Serial Configuration Slave

This block is a slave on a two-wire serial bus. The master drives the clock line. The data line is open-drain and shared. The block samples both lines with its own faster system clock. It finds start and stop conditions, compares the first byte after a start against a fixed 7-bit device address, and acknowledges by pulling the data line low. A write transfer begins with two throw-away bytes. After them, up to three configuration bytes are captured into latches, and any further bytes are acknowledged but dropped. A read transfer sends the latched bytes back to the master.

The latched bytes are decoded straight onto output pins that drive a downstream frequency synthesizer: a divider bypass flag, a source-select flag, a 6-bit input divider value, an 8-bit multiplier value, and a reserved byte. The block never drives the data line high. It only raises a pull-low enable that an external open-drain pad turns into a low level.

Top module: `cfg2w_slave`

## Requirements
- R1: After reset, all three configuration bytes are zero, so every field output is 0, and `sda_pull_o` is 0.
- R2: A start is a falling data line while the clock is high. A stop is a rising data line while the clock is high. After a stop, the slave ignores all bus activity, acknowledges nothing, and changes no latch until the next start.
- R3: The first byte after a start is the address 7'b1100101 sent MSB first, followed by the direction bit (0 = write, 1 = read). On a match the slave acknowledges. On a mismatch it gives no acknowledge and stays silent until the next start.
- R4: `sda_pull_o` only changes while the synchronized clock line is low. An acknowledge pull is therefore held through the whole high phase of the ninth clock, and it is released after that clock's falling edge.
- R5: On a write, the two bytes after the address are acknowledged and discarded. The next bytes go in order into Data0, Data1 and Data2.
- R6: On a write, every byte after the third data byte is acknowledged and changes no latch.
- R7: Data0 bit 7 drives `cnt_bypass_o`, Data0 bit 6 drives `prog_sel_o`, Data0 bits 5..0 drive `q_div_o`, Data1 drives `p_mul_o`, and Data2 drives `rsvd_o`.
- R8: On a read, the slave sends Data0 first, MSB first. Each time the master acknowledges, it sends the next byte (Data1, then Data2, then Data0 again).
- R9: When the master does not acknowledge a read byte, the slave releases the data line and does not drive it again before the next start.
- R10: A repeated start in the middle of any transfer restarts address decoding. The new direction bit then applies.
- R11: A latch changes only when a write byte of all eight bits has completed. A byte cut short by a stop writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both bus lines are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received from the pad |
| sda_i | input | 1 | Bus data line as received from the pad |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| cnt_bypass_o | output | 1 | Divider bypass flag (Data0 bit 7) |
| prog_sel_o | output | 1 | Programmed-value select flag (Data0 bit 6) |
| q_div_o | output | 6 | Input divider field (Data0 bits 5..0) |
| p_mul_o | output | 8 | Multiplier field (Data1) |
| rsvd_o | output | 8 | Reserved byte (Data2) |

## Verification
A change on either bus line reaches the state register on the third system clock edge after it: two synchronizer flops, then the state flop. The pull-low output and the latches therefore move three clocks after the bus clock edge that causes them. The bench holds every quarter of a bus bit for eight system clocks and samples at falling clock edges. An acknowledge is read in the middle of the ninth clock's high phase, and a released line is checked a full quarter after the falling edge. The field outputs are compared with the bench's model a few clocks after each stop, which is long after the last latch write.

// File: rtl/cfg2w_pkg.sv
package cfg2w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_AACK  = 3'd2,
        ST_WBYTE = 3'd3,
        ST_WACK  = 3'd4,
        ST_RBYTE = 3'd5,
        ST_RACK  = 3'd6
    } bus_st_e;

endpackage

// File: rtl/cfg2w_sync.sv
module cfg2w_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its history
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES+1){IDLE_VAL}};
        else        chain_q <= chain_d;
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];

endmodule

// File: rtl/cfg2w_regs.sv
module cfg2w_regs #(
    parameter int NUM_LATCH = 3,
    parameter int PTR_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [PTR_W-1:0]             wr_idx_i,
    input  logic [7:0]                   wr_data_i,
    output logic [NUM_LATCH-1:0][7:0]    bytes_o
);

    logic [NUM_LATCH-1:0][7:0] bytes_d, bytes_q;

    always_comb begin
        bytes_d = bytes_q;
        for (int i = 0; i < NUM_LATCH; i++) begin
            if (wr_en_i && (wr_idx_i == PTR_W'(i))) bytes_d[i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bytes_q <= '0;
        else        bytes_q <= bytes_d;
    end

    assign bytes_o = bytes_q;

endmodule

// File: rtl/cfg2w_engine.sv
module cfg2w_engine
    import cfg2w_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1100101,
    parameter int         DUMMY_BYTES = 2,
    parameter int         NUM_LATCH   = 3,
    parameter int         PTR_W       = 2,
    parameter int         CNT_W       = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_lvl_i,
    input  logic                      scl_rise_i,
    input  logic                      scl_fall_i,
    input  logic                      sda_lvl_i,
    input  logic                      sda_rise_i,
    input  logic                      sda_fall_i,
    input  logic [NUM_LATCH-1:0][7:0] rd_bytes_i,
    output logic                      pull_o,
    output logic                      wr_en_o,
    output logic [PTR_W-1:0]          wr_idx_o,
    output logic [7:0]                wr_data_o,
    output bus_st_e                   st_o
);

    localparam logic [CNT_W-1:0] WIN_LO   = CNT_W'(DUMMY_BYTES);
    localparam logic [CNT_W-1:0] WIN_HI   = CNT_W'(DUMMY_BYTES + NUM_LATCH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_LATCH - 1);

    typedef struct packed {
        bus_st_e          st;
        logic [3:0]       bitcnt;
        logic [7:0]       shift;
        logic             rw;
        logic [CNT_W-1:0] bidx;
        logic [PTR_W-1:0] rptr;
        logic             nack;
        logic             pull;
    } eng_t;

    eng_t             r_d, r_q;
    logic             start_c, stop_c, wr_en_c;
    logic [CNT_W-1:0] idx_off;
    logic [PTR_W-1:0] nxt_ptr;

    always_comb begin
        r_d     = r_q;
        wr_en_c = 1'b0;
        start_c = sda_fall_i & scl_lvl_i;
        stop_c  = sda_rise_i & scl_lvl_i;
        idx_off = r_q.bidx - WIN_LO;
        nxt_ptr = (r_q.rptr == PTR_LAST) ? '0 : r_q.rptr + 1'b1;

        if (start_c) begin
            r_d.st     = ST_ADDR;
            r_d.bitcnt = '0;
            r_d.pull   = 1'b0;
        end else if (stop_c) begin
            r_d.st     = ST_IDLE;
            r_d.bitcnt = '0;
            r_d.pull   = 1'b0;
        end else begin
            case (r_q.st)
                ST_ADDR, ST_WBYTE: begin
                    if (scl_rise_i && (r_q.bitcnt != 4'd8)) begin
                        r_d.shift  = {r_q.shift[6:0], sda_lvl_i};
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else if (scl_fall_i && (r_q.bitcnt == 4'd8)) begin
                        r_d.bitcnt = '0;
                        if (r_q.st == ST_ADDR) begin
                            if (r_q.shift[7:1] == DEV_ADDR) begin
                                r_d.rw   = r_q.shift[0];
                                r_d.st   = ST_AACK;
                                r_d.pull = 1'b1;
                                r_d.bidx = '0;
                                r_d.rptr = '0;
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else begin
                            wr_en_c = (r_q.bidx >= WIN_LO) && (r_q.bidx < WIN_HI);
                            if (r_q.bidx != WIN_HI) r_d.bidx = r_q.bidx + 1'b1;
                            r_d.st   = ST_WACK;
                            r_d.pull = 1'b1;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall_i) begin
                        r_d.bitcnt = '0;
                        if (r_q.rw) begin
                            r_d.st    = ST_RBYTE;
                            r_d.shift = rd_bytes_i[r_q.rptr];
                            r_d.pull  = ~rd_bytes_i[r_q.rptr][7];
                        end else begin
                            r_d.st   = ST_WBYTE;
                            r_d.pull = 1'b0;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall_i) begin
                        r_d.st   = ST_WBYTE;
                        r_d.pull = 1'b0;
                    end
                end
                ST_RBYTE: begin
                    if (scl_fall_i) begin
                        if (r_q.bitcnt == 4'd7) begin
                            r_d.st     = ST_RACK;
                            r_d.pull   = 1'b0;
                            r_d.bitcnt = '0;
                        end else begin
                            r_d.shift  = {r_q.shift[6:0], 1'b0};
                            r_d.pull   = ~r_q.shift[6];
                            r_d.bitcnt = r_q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) begin
                        r_d.nack = sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (r_q.nack) begin
                            r_d.st = ST_IDLE;
                        end else begin
                            r_d.rptr  = nxt_ptr;
                            r_d.shift = rd_bytes_i[nxt_ptr];
                            r_d.pull  = ~rd_bytes_i[nxt_ptr][7];
                            r_d.st    = ST_RBYTE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.bitcnt <= '0;
            r_q.shift  <= '0;
            r_q.rw     <= 1'b0;
            r_q.bidx   <= '0;
            r_q.rptr   <= '0;
            r_q.nack   <= 1'b0;
            r_q.pull   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pull_o    = r_q.pull;
    assign wr_en_o   = wr_en_c;
    assign wr_idx_o  = idx_off[PTR_W-1:0];
    assign wr_data_o = r_q.shift;
    assign st_o      = r_q.st;

endmodule

// File: rtl/cfg2w_slave.sv
module cfg2w_slave
    import cfg2w_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1100101,
    parameter int         DUMMY_BYTES = 2,
    parameter int         NUM_LATCH   = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic       cnt_bypass_o,
    output logic       prog_sel_o,
    output logic [5:0] q_div_o,
    output logic [7:0] p_mul_o,
    output logic [7:0] rsvd_o
);

    localparam int PTR_W = (NUM_LATCH > 1) ? $clog2(NUM_LATCH) : 1;
    localparam int CNT_W = $clog2(DUMMY_BYTES + NUM_LATCH + 1);

    // line 0 = bus clock, line 1 = bus data
    logic [1:0] raw_line, line_lvl, line_rise, line_fall;
    assign raw_line = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_sync
            cfg2w_sync #(
                .STAGES   (SYNC_STAGES),
                .IDLE_VAL (1'b1)
            ) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_i (raw_line[g]),
                .lvl_o  (line_lvl[g]),
                .rise_o (line_rise[g]),
                .fall_o (line_fall[g])
            );
        end
    endgenerate

    logic                      scl_lvl;
    logic                      wr_en;
    logic [PTR_W-1:0]          wr_idx;
    logic [7:0]                wr_data;
    logic [NUM_LATCH-1:0][7:0] latch_q;
    bus_st_e                   eng_st;

    assign scl_lvl = line_lvl[0];

    cfg2w_engine #(
        .DEV_ADDR    (DEV_ADDR),
        .DUMMY_BYTES (DUMMY_BYTES),
        .NUM_LATCH   (NUM_LATCH),
        .PTR_W       (PTR_W),
        .CNT_W       (CNT_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl_i  (scl_lvl),
        .scl_rise_i (line_rise[0]),
        .scl_fall_i (line_fall[0]),
        .sda_lvl_i  (line_lvl[1]),
        .sda_rise_i (line_rise[1]),
        .sda_fall_i (line_fall[1]),
        .rd_bytes_i (latch_q),
        .pull_o     (sda_pull_o),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data),
        .st_o       (eng_st)
    );

    cfg2w_regs #(
        .NUM_LATCH (NUM_LATCH),
        .PTR_W     (PTR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .bytes_o   (latch_q)
    );

    assign cnt_bypass_o = latch_q[0][7];
    assign prog_sel_o   = latch_q[0][6];
    assign q_div_o      = latch_q[0][5:0];
    assign p_mul_o      = latch_q[1];
    assign rsvd_o       = latch_q[2];

endmodule

// File: rtl/cfg2w_chk.sv
module cfg2w_chk
    import cfg2w_pkg::*;
#(
    parameter int CFG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             pull,
    input  bus_st_e          st,
    input  logic [CFG_W-1:0] cfg
);

    // R4: the pull-low enable moves only in a low phase of the bus clock
    a_r4_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pull != $past(pull)) |-> !$past(scl_lvl));

    // R11: latches are written only at a bus clock falling edge
    a_r11_latch_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != $past(cfg)) |-> !$past(scl_lvl));

    // R6: no latch changes except out of a write-byte phase
    a_r6_latch_only_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != $past(cfg)) |-> ($past(st) == ST_WBYTE));

    // R9: idle means released
    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !pull);

    // R3: the line is only pulled in acknowledge or read-data phases
    a_r3_pull_only_when_owned: assert property (@(posedge clk) disable iff (!rst_n)
        pull |-> ((st == ST_AACK) || (st == ST_WACK) || (st == ST_RBYTE)));

endmodule

bind cfg2w_slave cfg2w_chk #(.CFG_W(8 * NUM_LATCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_lvl (scl_lvl),
    .pull    (sda_pull_o),
    .st      (eng_st),
    .cfg     (latch_q)
);

// File: tb/sim_cfg2w_slave.sv
module sim_cfg2w_slave;

    localparam logic [6:0] ADDR = 7'b1100101;
    localparam int         QTR  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_pull;
    logic       cnt_bypass, prog_sel;
    logic [5:0] q_div;
    logic [7:0] p_mul, rsvd;

    assign sda_bus = sda_m & ~sda_pull;

    cfg2w_slave u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_pull_o   (sda_pull),
        .cnt_bypass_o (cnt_bypass),
        .prog_sel_o   (prog_sel),
        .q_div_o      (q_div),
        .p_mul_o      (p_mul),
        .rsvd_o       (rsvd)
    );

    always #10 clk = ~clk;

    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;
    logic [7:0] mdl [3];
    logic [7:0] dat [6];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq;
        repeat (QTR) @(negedge clk);
    endtask

    task automatic chk_fields(input string tag);
        chk({tag, " R7 bypass"}, 32'(cnt_bypass), 32'(mdl[0][7]));
        chk({tag, " R7 select"}, 32'(prog_sel),   32'(mdl[0][6]));
        chk({tag, " R7 qdiv"},   32'(q_div),      32'(mdl[0][5:0]));
        chk({tag, " R7 pmul"},   32'(p_mul),      32'(mdl[1]));
        chk({tag, " R7 rsvd"},   32'(rsvd),       32'(mdl[2]));
    endtask

    task automatic bus_start;
        if (!scl_m) begin
            sda_m = 1'b1; wq;
            scl_m = 1'b1; wq;
        end
        sda_m = 1'b0; wq;
        scl_m = 1'b0; wq;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq;
        scl_m = 1'b1; wq;
        sda_m = 1'b1; wq;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq;
            scl_m = 1'b1; wq; wq;
            scl_m = 1'b0; wq;
        end
        sda_m = 1'b1; wq;
        scl_m = 1'b1; wq;
        ack = ~sda_bus; wq;
        scl_m = 1'b0; wq;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wq;
            scl_m = 1'b1; wq;
            b = {b[6:0], sda_bus}; wq;
            scl_m = 1'b0;
        end
        sda_m = ~m_ack; wq;
        scl_m = 1'b1; wq; wq;
        scl_m = 1'b0; wq;
        sda_m = 1'b1;
    endtask

    task automatic wr_txn(input int n, input string tag);
        logic a;
        bus_start;
        send_byte({ADDR, 1'b0}, a);
        chk("R3 write address ack", 32'(a), 1);
        for (int k = 0; k < 2; k++) begin
            send_byte(8'($urandom), a);
            chk("R5 dummy byte ack", 32'(a), 1);
        end
        for (int k = 0; k < n; k++) begin
            send_byte(dat[k], a);
            if (k < 3) begin
                chk("R5 data byte ack R4", 32'(a), 1);
                mdl[k] = dat[k];
            end else begin
                chk("R6 extra byte ack", 32'(a), 1);
            end
        end
        chk("R4 released after ack", 32'(sda_pull), 0);
        bus_stop;
        repeat (4) @(negedge clk);
        chk_fields(tag);
    endtask

    task automatic rd_txn(input int n, input string tag);
        logic a;
        logic [7:0] b;
        bus_start;
        send_byte({ADDR, 1'b1}, a);
        chk("R3 read address ack", 32'(a), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk({tag, " R8 read byte"}, 32'(b), 32'(mdl[k % 3]));
        end
        scl_m = 1'b1; wq;
        chk("R9 released after nack", 32'(sda_pull), 0);
        scl_m = 1'b0; wq;
        bus_stop;
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        int unsigned seed;
        seed = $urandom(32'd4711);
        for (int k = 0; k < 3; k++) mdl[k] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk_fields("R1");
        chk("R1 pull idle", 32'(sda_pull), 0);

        // R5 R7 full write
        dat[0] = 8'hC5; dat[1] = 8'h3A; dat[2] = 8'h96;
        wr_txn(3, "R5 full write");
        chk("R7 bypass bit7", 32'(cnt_bypass), 1);
        chk("R7 select bit6", 32'(prog_sel), 1);
        chk("R7 qdiv bits", 32'(q_div), 32'h05);

        // R6 extra bytes ignored
        dat[0] = 8'h41; dat[1] = 8'h7E; dat[2] = 8'h0F; dat[3] = 8'hFF; dat[4] = 8'h00;
        wr_txn(5, "R6 extra bytes");

        // R5 partial and dummies only
        dat[0] = 8'h82;
        wr_txn(1, "R5 partial write");
        wr_txn(0, "R5 dummies only");

        // R3 address mismatch
        bus_start;
        send_byte({7'b1100100, 1'b0}, a);
        chk("R3 mismatch no ack", 32'(a), 0);
        send_byte(8'h00, a);
        chk("R3 silent after mismatch", 32'(a), 0);
        bus_stop;
        repeat (4) @(negedge clk);
        chk_fields("R3 mismatch");

        // R8 R9 read with wrap
        rd_txn(4, "R8 wrap");

        // R2 stop ends the transfer
        bus_start;
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        bus_stop;
        scl_m = 1'b0; wq;
        send_byte(8'h00, a);
        chk("R2 no ack after stop", 32'(a), 0);
        send_byte(8'hFF, a);
        chk("R2 no ack after stop 2", 32'(a), 0);
        bus_stop;
        repeat (4) @(negedge clk);
        chk_fields("R2 after stop");

        // R11 byte cut short by stop
        bus_start;
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        for (int i = 0; i < 4; i++) begin
            sda_m = ~mdl[0][7 - i]; wq;
            scl_m = 1'b1; wq; wq;
            scl_m = 1'b0; wq;
        end
        bus_stop;
        repeat (4) @(negedge clk);
        chk_fields("R11 partial byte");

        // R10 repeated start: write then read
        bus_start;
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h55, a);
        bus_start;
        send_byte({ADDR, 1'b1}, a);
        chk("R10 read ack after repeated start", 32'(a), 1);
        recv_byte(1'b0, b);
        chk("R10 read after repeated start", 32'(b), 32'(mdl[0]));
        bus_stop;

        // R10 mismatch then repeated start
        bus_start;
        send_byte({7'b0100101, 1'b0}, a);
        chk("R10 mismatch no ack", 32'(a), 0);
        bus_start;
        send_byte({ADDR, 1'b0}, a);
        chk("R10 ack after repeated start", 32'(a), 1);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        send_byte(8'h6D, a);
        mdl[0] = 8'h6D;
        bus_stop;
        repeat (4) @(negedge clk);
        chk_fields("R10 rewrite");

        // constrained random mix
        for (int t = 0; t < 14; t++) begin
            if (($urandom % 3) == 0) begin
                rd_txn(1 + int'($urandom % 5), "R8 random read");
            end else begin
                for (int k = 0; k < 6; k++) dat[k] = 8'($urandom);
                wr_txn(int'($urandom % 6), "R5 random write");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule